// File: doc/BRIEF.md
# Reset Cause Register

This block holds an 8-bit status word that records which sources have reset the chip since software last looked. Five event inputs feed it: power-on, external pin, supply brown-out, watchdog timeout and a reset requested through the debug port. Each event input is a single-cycle, already-synchronous pulse in the block's clock domain. The block does not create any reset and does not filter or synchronise the pin. It only latches the causes and reports them.

Software reaches the word over a small register bus with an address, a write strobe with write data, and a read strobe. Boot code reads the word early, works out why the chip restarted, then writes zeros to the bits it has handled. A write of one to a bit leaves it alone. When a power-on event arrives, every other cause is wiped and only the power-on bit remains. Nothing but a software write can clear the power-on bit, so it tells software that no other reset has cleared the word since power came up. The power-on event is also the block's own initialising event: until the first one, the contents are undefined.

Top module: `rst_cause_reg`

## Requirements
- R1: The flag positions are fixed: bit 0 power-on, bit 1 external pin, bit 2 brown-out, bit 3 watchdog, bit 4 debug-port reset request.
- R2: Bits 7, 6 and 5 of the read data are always zero.
- R3: A pulse on the external, brown-out, watchdog or debug-port event input sets its own flag at the clock edge where the pulse is sampled. The flag is visible to a read in the next cycle.
- R4: A power-on pulse clears the external, brown-out, watchdog and debug-port flags at the same edge, unless that flag's own event is high in that cycle.
- R5: A power-on pulse sets bit 0. No event input clears bit 0.
- R6: A write to the register address with a 0 in a flag bit clears that flag at the write edge.
- R7: A write with a 1 in a flag bit leaves that flag unchanged.
- R8: When a flag's own event and a software clear of that flag fall in the same cycle, the flag ends up set.
- R9: Read data is combinational. It carries the flags in the same cycle that the read strobe is high with the register address. In every other cycle it is all zeros.
- R10: Flags from several events build up together until software clears them.
- R11: A write to any other address changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_evt | input | 1 | Power-on event pulse; also initialises the block |
| ext_evt | input | 1 | External pin reset event pulse |
| bod_evt | input | 1 | Brown-out reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| dbg_evt | input | 1 | Debug-port reset request pulse |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; a 0 in a flag bit clears that flag |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, zero when not selected |

## Verification
A result is due at one of two times. Event pulses and writes change the flags at the edge that samples them, so the bench drives them just after one edge and reads in the following cycle. Read data is combinational, so it is due in the same cycle as the strobe. The bench raises the strobe just after an edge and its monitor compares at the falling edge of that same cycle. The bench queues each expected word when it issues the read, which keeps every comparison tied to the cycle its stimulus was meant for.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
    localparam int DATA_W  = 8;
    localparam int FLAG_N  = 5;
    localparam int IDX_POR = 0;
    localparam int IDX_EXT = 1;
    localparam int IDX_BOD = 2;
    localparam int IDX_WDT = 3;
    localparam int IDX_DBG = 4;
    localparam int PAD_W   = DATA_W - FLAG_N;
endpackage

// File: rtl/rst_cause_flag.sv
module rst_cause_flag #(
    parameter bit WIPE_ON_POR = 1'b1
) (
    input  logic clk,
    input  logic por_evt,
    input  logic set_evt,
    input  logic sw_clr,
    output logic flag_q
);
    // Set has priority, then a power-on wipe, then a software clear.
    always_ff @(posedge clk) begin
        if (set_evt)
            flag_q <= 1'b1;
        else if (WIPE_ON_POR && por_evt)
            flag_q <= 1'b0;
        else if (sw_clr)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/rst_cause_bus.sv
module rst_cause_bus
    import rst_cause_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h15
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [FLAG_N-1:0] flags,
    output logic [FLAG_N-1:0] sw_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic sel;
    assign sel = (bus_addr == REG_ADDR);

    always_comb begin
        sw_clr = {FLAG_N{bus_wr & sel}} & ~bus_wdata[FLAG_N-1:0];
    end

    always_comb begin
        if (bus_rd && sel)
            bus_rdata = {{PAD_W{1'b0}}, flags};
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h15
) (
    input  logic              clk,
    input  logic              por_evt,
    input  logic              ext_evt,
    input  logic              bod_evt,
    input  logic              wdt_evt,
    input  logic              dbg_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata
);
    logic [FLAG_N-1:0] evt_vec;
    logic [FLAG_N-1:0] sw_clr;
    logic [FLAG_N-1:0] flag_q;

    always_comb begin
        evt_vec          = '0;
        evt_vec[IDX_POR] = por_evt;
        evt_vec[IDX_EXT] = ext_evt;
        evt_vec[IDX_BOD] = bod_evt;
        evt_vec[IDX_WDT] = wdt_evt;
        evt_vec[IDX_DBG] = dbg_evt;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        if (i == IDX_POR) begin : g_por
            rst_cause_flag #(.WIPE_ON_POR(1'b0)) u_flag (
                .clk     (clk),
                .por_evt (por_evt),
                .set_evt (evt_vec[i]),
                .sw_clr  (sw_clr[i]),
                .flag_q  (flag_q[i])
            );
        end else begin : g_src
            rst_cause_flag #(.WIPE_ON_POR(1'b1)) u_flag (
                .clk     (clk),
                .por_evt (por_evt),
                .set_evt (evt_vec[i]),
                .sw_clr  (sw_clr[i]),
                .flag_q  (flag_q[i])
            );
        end
    end

    rst_cause_bus #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .flags     (flag_q),
        .sw_clr    (sw_clr),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h15
) (
    input logic              clk,
    input logic              por_evt,
    input logic              ext_evt,
    input logic              bod_evt,
    input logic              wdt_evt,
    input logic              dbg_evt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [4:0]        flag_q
);
    logic por_seen = 1'b0;
    always_ff @(posedge clk) if (por_evt) por_seen <= 1'b1;

    logic hit_wr, hit_rd;
    assign hit_wr = bus_wr && (bus_addr == REG_ADDR);
    assign hit_rd = bus_rd && (bus_addr == REG_ADDR);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!por_seen)
        bus_rdata[7:5] == 3'b000);
    // R3
    ext_set_chk: assert property (@(posedge clk) disable iff (!por_seen)
        ext_evt |=> flag_q[1]);
    // R3
    dbg_set_chk: assert property (@(posedge clk) disable iff (!por_seen)
        dbg_evt |=> flag_q[4]);
    // R4
    por_wipe_chk: assert property (@(posedge clk) disable iff (!por_seen)
        (por_evt && !wdt_evt) |=> !flag_q[3]);
    // R5
    por_set_chk: assert property (@(posedge clk) disable iff (!por_seen)
        por_evt |=> flag_q[0]);
    // R5
    por_hold_chk: assert property (@(posedge clk) disable iff (!por_seen)
        (flag_q[0] && !(hit_wr && !bus_wdata[0])) |=> flag_q[0]);
    // R6
    sw_clr_chk: assert property (@(posedge clk) disable iff (!por_seen)
        (hit_wr && !bus_wdata[2] && !bod_evt) |=> !flag_q[2]);
    // R7
    one_keep_chk: assert property (@(posedge clk) disable iff (!por_seen)
        (hit_wr && bus_wdata[1] && !ext_evt && !por_evt) |=> (flag_q[1] == $past(flag_q[1])));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_seen)
        (bod_evt && hit_wr && !bus_wdata[2]) |=> flag_q[2]);
    // R9
    rd_data_chk: assert property (@(posedge clk) disable iff (!por_seen)
        hit_rd |-> (bus_rdata[4:0] == flag_q));
    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!por_seen)
        !hit_rd |-> (bus_rdata == 8'h00));
endmodule

bind rst_cause_reg rst_cause_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk       (clk),
    .por_evt   (por_evt),
    .ext_evt   (ext_evt),
    .bod_evt   (bod_evt),
    .wdt_evt   (wdt_evt),
    .dbg_evt   (dbg_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .flag_q    (flag_q)
);

// File: tb/rst_cause_reg_bench.sv
`timescale 1ns/1ps
module rst_cause_reg_bench;
    localparam int              ADDR_W = 6;
    localparam logic [5:0]      RA     = 6'h15;
    localparam logic [5:0]      OTHER  = 6'h16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       por_evt = 0, ext_evt = 0, bod_evt = 0, wdt_evt = 0, dbg_evt = 0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    rst_cause_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) u_rst_cause_reg (
        .clk(clk), .por_evt(por_evt), .ext_evt(ext_evt), .bod_evt(bod_evt),
        .wdt_evt(wdt_evt), .dbg_evt(dbg_evt), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    typedef struct { logic [7:0] data; string tag; } item_t;
    item_t sb_q[$];
    int checks = 0, fails = 0;
    logic [4:0] model = '0;
    bit done = 0;

    // Expected flags from the requirements; ev order {dbg,wdt,bod,ext,por}
    function automatic logic [4:0] next_model(input logic [4:0] cur, input logic [4:0] ev,
                                              input logic hit, input logic [7:0] wd);
        logic [4:0] n;
        n[0] = ev[0] | (cur[0] & !(hit & !wd[0]));
        for (int i = 1; i < 5; i++)
            n[i] = ev[i] | (!ev[0] & cur[i] & !(hit & !wd[i]));
        return n;
    endfunction

    task automatic step(input logic [4:0] ev, input logic wr, input logic [7:0] wd,
                        input logic [5:0] a);
        @(posedge clk); #2;
        {dbg_evt, wdt_evt, bod_evt, ext_evt, por_evt} = ev;
        bus_wr = wr; bus_wdata = wd; bus_addr = a;
        model = next_model(model, ev, wr && (a == RA), wd);
        @(posedge clk); #2;
        {dbg_evt, wdt_evt, bod_evt, ext_evt, por_evt} = '0;
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.data = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1;
        @(posedge clk); #2;
        bus_rd = 0;
    endtask

    // Monitor: compares at the falling edge of the read cycle
    always @(negedge clk) begin
        item_t it;
        if (bus_rd) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected read actual=%02h expected=none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.data) begin
                    fails++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, bus_rdata, it.data);
                end
            end
        end
    end

    task automatic rd_model(input string tag);
        rd(RA, {3'b000, model}, tag);
    endtask

    initial begin
        step(5'b00001, 0, 8'h00, RA);
        rd_model("R1 R5 reset state");                     // 01
        @(negedge clk);
        checks++;
        if (bus_rdata !== 8'h00) begin
            fails++; $display("FAIL R9 idle actual=%02h expected=00", bus_rdata);
        end
        step(5'b00010, 0, 8'h00, RA); rd_model("R3 R1 external bit1");  // 03
        step(5'b00100, 0, 8'h00, RA); rd_model("R3 R10 brown-out bit2"); // 07
        step(5'b01000, 0, 8'h00, RA); rd_model("R3 R10 watchdog bit3");  // 0F
        step(5'b10000, 0, 8'h00, RA); rd_model("R2 R3 R10 debug bit4");  // 1F
        step(5'b00000, 1, 8'hFF, RA); rd_model("R7 write ones");          // 1F
        step(5'b00000, 1, 8'h00, OTHER); rd_model("R11 other address");   // 1F
        rd(OTHER, 8'h00, "R9 read other address");
        step(5'b00000, 1, 8'hFD, RA); rd_model("R6 clear bit1");          // 1D
        step(5'b00001, 0, 8'h00, RA); rd_model("R4 power-on wipe");       // 01
        step(5'b01010, 0, 8'h00, RA); rd_model("R10 two events");         // 0B
        step(5'b00000, 1, 8'hFE, RA); rd_model("R6 clear power-on bit");  // 0A
        step(5'b00001, 0, 8'h00, RA);
        step(5'b01000, 0, 8'h00, RA); rd_model("R5 bit0 kept by watchdog"); // 09
        step(5'b00100, 1, 8'h00, RA); rd_model("R8 set beats clear");     // 04
        step(5'b10001, 0, 8'h00, RA); rd_model("R4 R8 power-on with debug"); // 11
        step(5'b00000, 1, 8'hE0, RA); rd_model("R6 R2 clear all");         // 00
        if (sb_q.size() != 0) begin
            fails++; checks++;
            $display("FAIL R9 pending reads actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule